// File: doc/BRIEF.md
# Double-Buffered PWM Channel

This block is a single pulse-width modulator channel. An up-counter runs from zero to one below the programmed period and then wraps. A comparator sets the output level from the counter and the active duty value, and a polarity bit decides whether the duty count gives the high time or the low time of each period.

Software writes period, duty and polarity through a small register-style port. Each write lands first in a buffer. While the channel runs, the buffered values are copied into the active set only at safe points: when the counter wraps, when software writes the counter, or while the channel is disabled. Each output period therefore follows either the old settings or the new ones, and never a mix of the two. Readback returns the buffered values, so a read returns what was last written even when that value is not yet active.

Top module: `pwm_dbuf_chan`

## Requirements
- R1: While enabled with an active period P > 0, the counter steps through 0, 1, ..., P-1 and then returns to 0. With an active period of 0 it stays at 0.
- R2: While enabled, with active polarity 1 the output is high when count < duty and low otherwise. With active polarity 0 the output is low when count < duty and high otherwise.
- R3: While enabled, an active duty of 0 holds the output constant at the inverse of the polarity. An active duty >= the active period holds it constant at the polarity level, with no pulse at the period boundary.
- R4: While enabled, writes to duty, period or polarity change only the buffer. The active values change at the cycle where the counter wraps to 0, so the next period runs fully on the new values.
- R5: A counter write sets the counter to 0 on the next clock and loads all buffered values into the active set in the same cycle. The write data is ignored.
- R6: While disabled, the counter is held at 0, the output sits at the inverse of the active polarity, and every write updates the buffer and the active value together.
- R7: Readback on rd_data_o returns the buffered value selected by rd_sel_i (0 duty, 1 period, 2 polarity in bit 0, 3 live counter), one cycle after a write at the latest.
- R8: After reset, duty, period and polarity are zero in both the buffer and the active set, the counter is 0, and the output is high.
- R9: The write select encodes 0 duty, 1 period, 2 polarity (bit 0 of the data), and 3 counter write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Channel enable |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write target select |
| wr_data_i | input | WIDTH | Write data |
| rd_sel_i | input | 2 | Readback select |
| rd_data_o | output | WIDTH | Buffered register or counter value |
| cnt_o | output | WIDTH | Current counter value |
| pwm_o | output | 1 | PWM output |

## Verification
The assertions check on every cycle that the counter stays below the active period and clears on a counter write or while disabled. They also check that the active values hold still between safe points, that writes made while disabled go straight through, and that the idle, zero-duty and full-duty levels are correct. What the assertions cannot show is that the waveform inside each period has the right width for every period, duty and polarity combination, or that a write made mid-period takes effect exactly at the next wrap. The bench sweeps a grid of settings and runs ordered write sequences against an arithmetic model to cover those points.

// File: rtl/pwm_dbuf_pkg.sv
package pwm_dbuf_pkg;
  typedef enum logic [1:0] {
    SEL_DUTY = 2'd0,
    SEL_PER  = 2'd1,
    SEL_POL  = 2'd2,
    SEL_CNT  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/pwm_shadow_reg.sv
module pwm_shadow_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             load_i,
  output logic [WIDTH-1:0] buf_o,
  output logic [WIDTH-1:0] act_o
);
  logic [WIDTH-1:0] buf_nxt;

  assign buf_nxt = wr_i ? data_i : buf_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_o <= '0;
      act_o <= '0;
    end else begin
      buf_o <= buf_nxt;
      if (load_i) act_o <= buf_nxt;
    end
  end

  AST_BUF_TRACKS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> buf_o == $past(data_i)); // R7
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             clr_i,
  input  logic [WIDTH-1:0] per_i,
  output logic [WIDTH-1:0] cnt_o,
  output logic             wrap_o
);
  logic [WIDTH:0] cnt_inc;

  assign cnt_inc = {1'b0, cnt_o} + 1'b1;
  // period of 0 wraps every cycle, which pins the count at 0
  assign wrap_o  = en_i && !clr_i && (cnt_inc >= {1'b0, per_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_o <= '0;
    else if (!en_i || clr_i || wrap_o) cnt_o <= '0;
    else                            cnt_o <= cnt_inc[WIDTH-1:0];
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> ((per_i == '0) ? (cnt_o == '0) : (cnt_o < per_i))); // R1
  AST_CLR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_o == '0); // R5
  AST_DIS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> cnt_o == '0); // R6
endmodule

// File: rtl/pwm_out_stage.sv
module pwm_out_stage #(
  parameter int WIDTH = 8
) (
  input  logic             en_i,
  input  logic             pol_i,
  input  logic [WIDTH-1:0] duty_i,
  input  logic [WIDTH-1:0] cnt_i,
  output logic             pwm_o
);
  logic in_first_phase;

  assign in_first_phase = cnt_i < duty_i;

  always_comb begin
    if (!en_i)      pwm_o = !pol_i;
    else if (pol_i) pwm_o = in_first_phase;
    else            pwm_o = !in_first_phase;
  end
endmodule

// File: rtl/pwm_dbuf_chan.sv
module pwm_dbuf_chan
  import pwm_dbuf_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_sel_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic [1:0]       rd_sel_i,
  output logic [WIDTH-1:0] rd_data_o,
  output logic [WIDTH-1:0] cnt_o,
  output logic             pwm_o
);
  localparam int PolW = 1;

  logic             wr_duty, wr_per, wr_pol, cnt_clr;
  logic             wrap, load;
  logic [WIDTH-1:0] duty_buf, duty_act, per_buf, per_act;
  logic [PolW-1:0]  pol_buf, pol_act;

  assign wr_duty = wr_en_i && (wr_sel_i == SEL_DUTY);
  assign wr_per  = wr_en_i && (wr_sel_i == SEL_PER);
  assign wr_pol  = wr_en_i && (wr_sel_i == SEL_POL);
  assign cnt_clr = wr_en_i && (wr_sel_i == SEL_CNT);
  // safe points for moving buffered values into the active set
  assign load    = !en_i || cnt_clr || wrap;

  pwm_shadow_reg #(.WIDTH(WIDTH)) duty_reg_i (
    .clk_i, .rst_ni, .wr_i(wr_duty), .data_i(wr_data_i),
    .load_i(load), .buf_o(duty_buf), .act_o(duty_act));

  pwm_shadow_reg #(.WIDTH(WIDTH)) per_reg_i (
    .clk_i, .rst_ni, .wr_i(wr_per), .data_i(wr_data_i),
    .load_i(load), .buf_o(per_buf), .act_o(per_act));

  pwm_shadow_reg #(.WIDTH(PolW)) pol_reg_i (
    .clk_i, .rst_ni, .wr_i(wr_pol), .data_i(wr_data_i[PolW-1:0]),
    .load_i(load), .buf_o(pol_buf), .act_o(pol_act));

  pwm_counter #(.WIDTH(WIDTH)) cnt_i (
    .clk_i, .rst_ni, .en_i, .clr_i(cnt_clr), .per_i(per_act),
    .cnt_o, .wrap_o(wrap));

  pwm_out_stage #(.WIDTH(WIDTH)) out_i (
    .en_i, .pol_i(pol_act[0]), .duty_i(duty_act), .cnt_i(cnt_o), .pwm_o);

  always_comb begin
    unique case (rd_sel_i)
      SEL_DUTY: rd_data_o = duty_buf;
      SEL_PER:  rd_data_o = per_buf;
      SEL_POL:  rd_data_o = {{(WIDTH-PolW){1'b0}}, pol_buf};
      default:  rd_data_o = cnt_o;
    endcase
  end

  AST_ACT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !cnt_clr && !wrap |=> $stable(duty_act) && $stable(per_act) && $stable(pol_act)); // R4
  AST_DIS_DIRECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i && wr_duty |=> duty_act == $past(wr_data_i)); // R6
  AST_IDLE_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> pwm_o != pol_act[0]); // R6
  AST_DUTY_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && duty_act == '0 |-> pwm_o != pol_act[0]); // R3
  AST_DUTY_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && per_act != '0 && duty_act >= per_act |-> pwm_o == pol_act[0]); // R3
endmodule

// File: tb/pwm_dbuf_chan_tb_top.sv
module pwm_dbuf_chan_tb_top;
  localparam int W = 8;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         en_i = 1'b0;
  logic         wr_en_i = 1'b0;
  logic [1:0]   wr_sel_i = 2'd0;
  logic [W-1:0] wr_data_i = '0;
  logic [1:0]   rd_sel_i = 2'd0;
  logic [W-1:0] rd_data_o, cnt_o;
  logic         pwm_o;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // requirement model state
  int m_cnt, m_duty_b, m_duty_a, m_per_b, m_per_a, m_pol_b, m_pol_a;

  always #5 clk_i = ~clk_i;

  pwm_dbuf_chan #(.WIDTH(W)) dut_i (
    .clk_i, .rst_ni, .en_i, .wr_en_i, .wr_sel_i, .wr_data_i,
    .rd_sel_i, .rd_data_o, .cnt_o, .pwm_o);

  task automatic check(input string req, input string what, input int got, input int exp);
    n_checks++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  function automatic int exp_pwm();
    if (!en_i) return m_pol_a ? 0 : 1;
    if (m_pol_a != 0) return (m_cnt < m_duty_a) ? 1 : 0;
    return (m_cnt < m_duty_a) ? 0 : 1;
  endfunction

  function automatic int exp_rd(input int sel);
    case (sel)
      0: return m_duty_b;
      1: return m_per_b;
      2: return m_pol_b;
      default: return m_cnt;
    endcase
  endfunction

  // one clock: drive at negedge, update model, check at next negedge
  task automatic cyc(input string req, input bit en, input bit wr, input int sel,
                     input int data, input int rsel);
    bit clr, wrap, load;
    en_i = en; wr_en_i = wr; wr_sel_i = sel[1:0]; wr_data_i = data[W-1:0];
    rd_sel_i = rsel[1:0];
    clr  = wr && sel == 3;
    wrap = en && !clr && (m_cnt + 1 >= m_per_a);
    load = !en || clr || wrap;
    if (wr && sel == 0) m_duty_b = data;
    if (wr && sel == 1) m_per_b = data;
    if (wr && sel == 2) m_pol_b = data & 1;
    if (load) begin
      m_duty_a = m_duty_b; m_per_a = m_per_b; m_pol_a = m_pol_b;
    end
    m_cnt = load ? 0 : m_cnt + 1;
    @(posedge clk_i);
    @(negedge clk_i);
    check(req, "cnt_o", int'(cnt_o), m_cnt);
    check(req, "pwm_o", int'(pwm_o), exp_pwm());
    check(req, "rd_data_o", int'(rd_data_o), exp_rd(rsel));
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    m_cnt = 0; m_duty_b = 0; m_duty_a = 0; m_per_b = 0; m_per_a = 0; m_pol_b = 0; m_pol_a = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R8: reset state, idle output high, all buffers zero
    check("R8", "cnt_o", int'(cnt_o), 0);
    check("R8", "pwm_o", int'(pwm_o), 1);
    for (int s = 0; s < 4; s++) cyc("R8", 0, 0, 0, 0, s);

    // R1 R2 R3 R6 R9: grid of polarity, period and duty
    for (int pol = 0; pol < 2; pol++) begin
      for (int per = 0; per < 6; per++) begin
        for (int duty = 0; duty < 7; duty++) begin
          cyc("R9", 0, 1, 1, per, 1);
          cyc("R6", 0, 1, 0, duty, 0);
          cyc("R6", 0, 1, 2, pol, 2);
          for (int k = 0; k < 2 * per + 2; k++) begin
            if (duty == 0 || duty >= per) cyc("R3", 1, 0, 0, 0, 3);
            else                          cyc("R2", 1, 0, 0, 0, 3);
          end
          cyc("R1", 1, 0, 0, 0, 3);
        end
      end
    end

    // R4 R7: mid-period duty write waits for the wrap
    cyc("R6", 0, 1, 1, 5, 1);
    cyc("R6", 0, 1, 0, 2, 0);
    cyc("R6", 0, 1, 2, 1, 2);
    cyc("R4", 1, 0, 0, 0, 0);
    cyc("R4", 1, 1, 0, 4, 0);
    for (int k = 0; k < 8; k++) cyc("R7", 1, 0, 0, 0, 0);
    // R4: period and polarity change mid-period
    cyc("R4", 1, 1, 1, 3, 1);
    cyc("R4", 1, 1, 2, 0, 2);
    cyc("R4", 1, 1, 0, 1, 0);
    for (int k = 0; k < 10; k++) cyc("R4", 1, 0, 0, 0, 3);
    // R5: counter write with pending values, data ignored
    cyc("R5", 1, 1, 1, 6, 1);
    cyc("R5", 1, 1, 0, 5, 0);
    cyc("R5", 1, 1, 3, 8'hA5, 3);
    for (int k = 0; k < 8; k++) cyc("R5", 1, 0, 0, 0, 3);
    cyc("R5", 1, 1, 3, 0, 3);
    cyc("R5", 1, 0, 0, 0, 3);
    // R6: disable mid-period, writes go straight through
    cyc("R6", 1, 0, 0, 0, 3);
    cyc("R6", 0, 0, 0, 0, 3);
    cyc("R6", 0, 1, 2, 1, 2);
    cyc("R6", 0, 1, 0, 3, 0);
    cyc("R6", 0, 0, 0, 0, 3);
    for (int k = 0; k < 7; k++) cyc("R2", 1, 0, 0, 0, 3);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule